// File: doc/BRIEF.md
# Dual-Order Burst Address Sequencer

This block produces the low address bits of a four-beat memory burst. When an access starts, the memory access controller pulses a load strobe together with the two low bits of the requested address. The sequencer stores that start value and clears an internal beat count. Each clock edge at which the active-low step input is low moves the burst to its next address. The upper address bits belong to the controller and are never touched here, so the burst wraps inside its aligned four-word window.

Two orders are available. In linear order each beat is the start value plus the beat count, modulo four. In interleaved order each beat is the start value XOR the beat count. A strap input picks the order. The strap is captured when a burst is loaded, and it defaults to interleaved while reset is asserted. Changing the strap in the middle of a burst therefore has no effect until the next load.

Top module: `burst_order_seq`

## Requirements
- R1: While reset is asserted and after it is released, with no load yet, the address output is 00 and the beat output is 00. The captured order is interleaved.
- R2: A load at a clock edge stores the start input and sets the beat output to 00, so that the address output equals the start value. The load wins over a simultaneous low on the step input.
- R3: With load low and step high at a clock edge, the address and beat outputs keep their values.
- R4: With load low and step low at a clock edge, the beat output increments by one modulo four. After the fourth beat it wraps to 00, and the address returns to the start value. No carry ever leaves the two-bit field.
- R5: Order input 0, captured at load, selects linear order: address = (start + beat) mod 4. Start 00 gives 00,01,10,11. Start 01 gives 01,10,11,00. Start 10 gives 10,11,00,01. Start 11 gives 11,00,01,10.
- R6: Order input 1, captured at load, selects interleaved order: address = start XOR beat. Start 00 gives 00,01,10,11. Start 01 gives 01,00,11,10. Start 10 gives 10,11,00,01. Start 11 gives 11,10,01,00.
- R7: The order input is sampled only at a load. A change between loads leaves the running burst in the order it was loaded with.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Starts a burst: captures start value and order |
| start_addr_i | input | 2 | Low address bits of the access start |
| step_n_i | input | 1 | Active-low advance to the next beat |
| order_i | input | 1 | 0 = linear, 1 = interleaved; sampled at load |
| addr_o | output | 2 | Current low address bits of the burst |
| beat_o | output | 2 | Index of the current beat, 0 to 3 |

## Verification
The bench loads each of the four start values in both orders and steps through a full burst and one beat past it. A design that confused the two orders would go wrong on odd start values, for example producing 10 instead of 00 after start 01. A design that stopped at the fourth beat, or let the count carry, would miss the return to the start address. Other directed cases apply a load and a step in the same cycle, which a design that gave the step priority would turn into beat 01. They also flip the order input mid-burst, which a design without a captured order would follow at once. Random cycles with frequent reloads then compare every beat against a bench model.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

   // Which burst orders the map stage is built with.
   typedef enum logic [1:0] {
      ORD_BOTH        = 2'd0,   // runtime choice through the order input
      ORD_LINEAR_ONLY = 2'd1,   // wrapping increment only
      ORD_XOR_ONLY    = 2'd2    // interleaved only
   } order_set_e;

   // Order value captured while reset is asserted.
   localparam logic ORDER_RESET_VAL = 1'b1;

endpackage

// File: rtl/burst_seq_cnt.sv
module burst_seq_cnt #(
   parameter int W = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic         step_n_i,
   output logic [W-1:0] cnt_o
);

   localparam logic [W-1:0] CNT_ZERO = '0;
   localparam logic [W-1:0] CNT_ONE  = W'(1);

   logic [W-1:0] cnt_q;
   logic [W-1:0] cnt_d;

   // Load clears the beat count. A low step advances it, and it wraps
   // naturally at the width of the field.
   always_comb begin
      cnt_d = cnt_q;
      if (load_i) begin
         cnt_d = CNT_ZERO;
      end else if (!step_n_i) begin
         cnt_d = cnt_q + CNT_ONE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= CNT_ZERO;
      end else begin
         cnt_q <= cnt_d;
      end
   end

   assign cnt_o = cnt_q;

endmodule

// File: rtl/burst_seq_hold.sv
module burst_seq_hold #(
   parameter int   W         = 2,
   parameter logic MODE_INIT = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] start_i,
   input  logic         order_i,
   output logic [W-1:0] start_o,
   output logic         order_o
);

   logic [W-1:0] start_q;
   logic         order_q;

   // The start value and the order are both captured only at a load.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_q <= '0;
         order_q <= MODE_INIT;
      end else if (load_i) begin
         start_q <= start_i;
         order_q <= order_i;
      end
   end

   assign start_o = start_q;
   assign order_o = order_q;

endmodule

// File: rtl/burst_seq_map.sv
module burst_seq_map
   import burst_seq_pkg::*;
#(
   parameter int         W         = 2,
   parameter order_set_e ORDER_SET = ORD_BOTH
) (
   input  logic [W-1:0] start_i,
   input  logic [W-1:0] cnt_i,
   input  logic         order_i,
   output logic [W-1:0] addr_o
);

   logic [W-1:0] lin_addr;
   logic [W-1:0] xor_addr;

   // Both candidate orders are formed inside the field width.
   // The sum drops its carry, so the burst never leaves its window.
   assign lin_addr = start_i + cnt_i;

   for (genvar b = 0; b < W; b++) begin : g_xor_bit
      assign xor_addr[b] = start_i[b] ^ cnt_i[b];
   end

   if (ORDER_SET == ORD_LINEAR_ONLY) begin : g_lin
      assign addr_o = lin_addr;
   end else if (ORDER_SET == ORD_XOR_ONLY) begin : g_xor
      assign addr_o = xor_addr;
   end else begin : g_both
      assign addr_o = order_i ? xor_addr : lin_addr;
   end

   // In the fixed variants the order input is not used.
   logic unused_order;
   assign unused_order = (ORDER_SET != ORD_BOTH) & order_i;

endmodule

// File: rtl/burst_order_seq.sv
module burst_order_seq
   import burst_seq_pkg::*;
#(
   parameter int         W         = 2,
   parameter order_set_e ORDER_SET = ORD_BOTH
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] start_addr_i,
   input  logic         step_n_i,
   input  logic         order_i,
   output logic [W-1:0] addr_o,
   output logic [W-1:0] beat_o
);

   localparam int BEATS = 1 << W;

   if (W < 1 || W > 8) begin : g_bad_width
      $error("burst_order_seq: W must lie in 1..8, got %0d", W);
   end
   if (BEATS < 2) begin : g_bad_beats
      $error("burst_order_seq: a burst needs at least two beats");
   end

   logic [W-1:0] cnt;
   logic [W-1:0] start_q;
   logic         order_q;

   burst_seq_cnt #(
      .W (W)
   ) i_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (load_i),
      .step_n_i (step_n_i),
      .cnt_o    (cnt)
   );

   burst_seq_hold #(
      .W         (W),
      .MODE_INIT (ORDER_RESET_VAL)
   ) i_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (load_i),
      .start_i (start_addr_i),
      .order_i (order_i),
      .start_o (start_q),
      .order_o (order_q)
   );

   burst_seq_map #(
      .W         (W),
      .ORDER_SET (ORDER_SET)
   ) i_map (
      .start_i (start_q),
      .cnt_i   (cnt),
      .order_i (order_q),
      .addr_o  (addr_o)
   );

   assign beat_o = cnt;

endmodule

// File: rtl/burst_seq_chk.sv
module burst_seq_chk
   import burst_seq_pkg::*;
#(
   parameter int         W         = 2,
   parameter order_set_e ORDER_SET = ORD_BOTH
) (
   input logic         clk,
   input logic         rst_n,
   input logic         load_i,
   input logic [W-1:0] start_addr_i,
   input logic         step_n_i,
   input logic         order_i,
   input logic [W-1:0] addr_o,
   input logic [W-1:0] beat_o
);

   localparam logic [W-1:0] ONE = W'(1);
   localparam bit BOTH = (ORDER_SET == ORD_BOTH);

   // The checker keeps its own record of the order seen at the last load.
   logic order_ref;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      order_ref <= ORDER_RESET_VAL;
      else if (load_i) order_ref <= order_i;
   end

   // R1: outputs are zero while reset is held.
   always @(posedge clk) begin
      if (!rst_n) begin
         a_r1_reset_zero: assert (addr_o == '0 && beat_o == '0)
            else $error("R1: outputs not zero in reset");
      end
   end

   a_r2_load_start: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (beat_o == '0 && addr_o == $past(start_addr_i)))
      else $error("R2: load did not restart the burst");

   a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && step_n_i) |=> ($stable(addr_o) && $stable(beat_o)))
      else $error("R3: outputs moved without a step");

   a_r4_beat_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && !step_n_i) |=> (beat_o == $past(beat_o) + ONE))
      else $error("R4: beat did not advance by one");

   a_r5_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
      (BOTH && !load_i && !step_n_i && !order_ref) |=> (addr_o == $past(addr_o) + ONE))
      else $error("R5: linear address did not increment");

   a_r6_xor_step: assert property (@(posedge clk) disable iff (!rst_n)
      (BOTH && !load_i && !step_n_i && order_ref)
         |=> ((addr_o ^ $past(addr_o)) == (beat_o ^ $past(beat_o))))
      else $error("R6: interleaved address broke the XOR relation");

endmodule

bind burst_order_seq burst_seq_chk #(
   .W         (W),
   .ORDER_SET (ORDER_SET)
) i_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .load_i       (load_i),
   .start_addr_i (start_addr_i),
   .step_n_i     (step_n_i),
   .order_i      (order_i),
   .addr_o       (addr_o),
   .beat_o       (beat_o)
);

// File: tb/test_burst_order_seq.sv
`timescale 1ns/1ps
module test_burst_order_seq;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       load_i = 1'b0;
   logic [1:0] start_addr_i = 2'b00;
   logic       step_n_i = 1'b1;
   logic       order_i = 1'b1;
   logic [1:0] addr_o;
   logic [1:0] beat_o;

   int n_checks = 0;
   int n_fail   = 0;

   logic [1:0] m_start = 2'b00;
   logic [1:0] m_cnt   = 2'b00;
   logic       m_mode  = 1'b1;

   always #2 clk = ~clk;

   burst_order_seq i_burst_order_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .load_i       (load_i),
      .start_addr_i (start_addr_i),
      .step_n_i     (step_n_i),
      .order_i      (order_i),
      .addr_o       (addr_o),
      .beat_o       (beat_o)
   );

   function automatic logic [1:0] exp_addr(logic [1:0] s, logic [1:0] c, logic m);
      return m ? (s ^ c) : 2'(s + c);
   endfunction

   task automatic chk(string req, logic [1:0] got, logic [1:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
      end
   endtask

   // Called at a falling edge. Drives inputs, waits one rising edge,
   // updates the model, and returns at the next falling edge.
   task automatic tick(logic ld, logic [1:0] sa, logic sn, logic md);
      load_i = ld; start_addr_i = sa; step_n_i = sn; order_i = md;
      @(posedge clk);
      if (ld) begin
         m_start = sa; m_cnt = 2'b00; m_mode = md;
      end else if (!sn) begin
         m_cnt = m_cnt + 2'b01;
      end
      @(negedge clk);
   endtask

   task automatic chk_model(string req);
      chk(req, addr_o, exp_addr(m_start, m_cnt, m_mode));
      chk(req, beat_o, m_cnt);
   endtask

   initial begin
      #800000;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      logic [1:0] lin_tab [4][4];
      logic [1:0] xor_tab [4][4];
      lin_tab = '{'{2'b00,2'b01,2'b10,2'b11}, '{2'b01,2'b10,2'b11,2'b00},
                  '{2'b10,2'b11,2'b00,2'b01}, '{2'b11,2'b00,2'b01,2'b10}};
      xor_tab = '{'{2'b00,2'b01,2'b10,2'b11}, '{2'b01,2'b00,2'b11,2'b10},
                  '{2'b10,2'b11,2'b00,2'b01}, '{2'b11,2'b10,2'b01,2'b00}};
      void'($urandom(32'd5150));

      repeat (3) @(negedge clk);
      chk("R1 in reset addr", addr_o, 2'b00);
      chk("R1 in reset beat", beat_o, 2'b00);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after reset addr", addr_o, 2'b00);
      chk("R1 after reset beat", beat_o, 2'b00);
      // R1: the order after reset is interleaved; start 00 still counts up
      tick(1'b0, 2'b11, 1'b0, 1'b0);
      chk("R1 default order step", addr_o, 2'b01);
      tick(1'b0, 2'b11, 1'b1, 1'b0);
      chk("R3 hold addr", addr_o, 2'b01);
      chk("R3 hold beat", beat_o, 2'b01);

      // R5 and R6: full tables, plus one beat past the end (R4 wrap)
      for (int md = 0; md < 2; md++) begin
         for (int s = 0; s < 4; s++) begin
            tick(1'b1, 2'(s), 1'b1, md[0]);
            for (int b = 0; b < 4; b++) begin
               chk(md ? "R6 order" : "R5 order", addr_o, md ? xor_tab[s][b] : lin_tab[s][b]);
               chk("R4 beat", beat_o, 2'(b));
               tick(1'b0, 2'(s), 1'b0, md[0]);
            end
            chk("R4 wrap to start", addr_o, 2'(s));
            chk("R4 wrap beat", beat_o, 2'b00);
         end
      end

      // R2: load wins over a simultaneous step
      tick(1'b0, 2'b00, 1'b0, 1'b0);
      tick(1'b1, 2'b10, 1'b0, 1'b0);
      chk("R2 load beats step addr", addr_o, 2'b10);
      chk("R2 load beats step beat", beat_o, 2'b00);

      // R7: order flipped mid-burst is ignored until the next load
      tick(1'b1, 2'b01, 1'b1, 1'b0);
      tick(1'b0, 2'b00, 1'b0, 1'b1);
      chk("R7 keeps linear", addr_o, 2'b10);
      tick(1'b0, 2'b00, 1'b0, 1'b1);
      chk("R7 keeps linear", addr_o, 2'b11);
      tick(1'b1, 2'b01, 1'b1, 1'b1);
      tick(1'b0, 2'b00, 1'b0, 1'b0);
      chk("R7 keeps interleaved", addr_o, 2'b00);
      tick(1'b0, 2'b00, 1'b0, 1'b0);
      chk("R7 keeps interleaved", addr_o, 2'b11);

      // Random traffic against the model
      for (int i = 0; i < 4000; i++) begin
         tick(($urandom % 6) == 0, 2'($urandom), 1'($urandom), 1'($urandom));
         chk_model("R2-7 random");
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule